// File: doc/BRIEF.md
# Nonvolatile Byte Write Engine with Completion Status

This block carries out the write-class operations that an upstream command decoder hands to it: programming one byte, erasing the whole array, and setting a permanent boot-region lock. It works on a small behavioural byte array. An internal cycle counter sets the duration of each operation, so the time an operation takes is a parameter given in clock cycles.

While an operation runs, the block reports its progress in three independent ways. A read returns a status word instead of array contents. In that word, bit 7 holds the inverse of bit 7 of the byte last loaded, and bit 6 changes value on every read. In addition, a ready line is held low for the whole operation.

The lowest `BOOT_BYTES` addresses form a boot region. Once the lock is set, programs aimed at that region are refused and erases skip it. The exception is when a high-voltage override input is asserted while the request is accepted. A synchronous low reset aborts whatever is running, disables the read output and returns the block to plain reads.

Top module: `nvm_write_engine`

## Requirements
- R1: A program request (`req_op` = 2'b01) stores `old & new` at `req_addr`, so bits only go from 1 to 0. The array powers up with every byte at FFh.
- R2: An erase request (`req_op` = 2'b10) sets every byte to FFh when it completes, unless R3 applies.
- R3: While the lock is set and `hv_override` is low at acceptance, an erase leaves the bytes at addresses below `BOOT_BYTES` unchanged. With `hv_override` high, those bytes are erased too.
- R4: A read issued while busy returns `{~L[7], T, 6'b0}`, where L is the byte last loaded (FFh for an erase or lock request), regardless of `rd_addr`. After completion, a read returns the true stored byte.
- R5: While busy, bit 6 of the status word is 0 on the first read after acceptance and flips on each later read of the same operation.
- R6: `ready_line` goes low in the cycle after acceptance. It stays low for exactly `PROG_CYCLES` cycles for a program or lock request and `ERASE_CYCLES` cycles for an erase request, then returns high.
- R7: A lock request (`req_op` = 2'b11) sets `boot_locked` when it completes. Nothing clears it, including reset.
- R8: While locked, a program request to an address below `BOOT_BYTES` with `hv_override` low is not accepted: `ready_line` stays high and the byte is unchanged. With `hv_override` high, the request proceeds.
- R9: Requests presented while busy, and requests with `req_op` = 2'b00, are ignored.
- R10: While `rst_n` is low, `rd_oe` is low and the running operation is abandoned. After release, `ready_line` is high. Only the target byte of an aborted program may differ from its old value.
- R11: `rd_data` and `rd_oe` = 1 appear in the cycle after `rd_en`. In a cycle with no read in the previous cycle, `rd_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; aborts the running operation |
| req_valid | input | 1 | Request strobe from the command decoder |
| req_op | input | 2 | 01 program, 10 erase, 11 lock, 00 none |
| req_addr | input | ADDR_W | Program target address |
| req_data | input | 8 | Program data |
| hv_override | input | 1 | Boot-region protection override, sampled at acceptance |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read result or status word |
| rd_oe | output | 1 | Read output enable (0 means high impedance) |
| ready_line | output | 1 | 0 while an operation runs (the pull-low state) |
| boot_locked | output | 1 | Boot-region lock state |

## Verification
The assertions check the following on every cycle:
- the ready line drops one cycle after every acceptance and rises after every completion;
- a refused boot program never makes the block busy;
- a read while busy carries the inverted polling bit, and bit 6 differs between back-to-back busy reads;
- the lock never clears;
- reset forces the output enable low.

Only the bench scenarios can show the rest:
- the exact busy lengths;
- the AND-merge of repeated programs;
- which bytes an erase keeps, with and without the override;
- that a request during busy leaves the array unchanged;
- that an abort disturbs nothing but its target byte.

// File: rtl/nvm_eng_pkg.sv
package nvm_eng_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_LOCK  = 2'b11
  } op_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  // Programming can only clear bits.
  function automatic logic [7:0] merge_prog(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

  // Status word shown on reads while busy.
  function automatic logic [7:0] poll_word(input logic [7:0] loaded, input logic tog);
    return {~loaded[7], tog, 6'b000000};
  endfunction

endpackage

// File: rtl/nvm_op_timer.sv
module nvm_op_timer #(
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic long_op,
  output logic busy,
  output logic done
);
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= long_op ? CNT_W'(ERASE_CYCLES - 1) : CNT_W'(PROG_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign done = rst_n && busy_q && (cnt_q == '0);
endmodule

// File: rtl/nvm_array.sv
module nvm_array
  import nvm_eng_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int BOOT_BYTES = 16
) (
  input  logic              clk,
  input  logic              commit,
  input  op_e               op,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              keep_boot,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_byte,
  output logic              locked
);
  localparam int DEPTH = 1 << ADDR_W;

  // Nonvolatile contents: not touched by reset, erased at power-up.
  logic [7:0] mem [DEPTH] = '{default: ERASED_BYTE};
  logic       lock_q      = 1'b0;

  always_ff @(posedge clk) begin
    if (commit) begin
      case (op)
        OP_PROG:  mem[wr_addr] <= merge_prog(mem[wr_addr], wr_data);
        OP_ERASE: begin
          for (int i = 0; i < DEPTH; i++) begin
            if (!(keep_boot && (i < BOOT_BYTES))) mem[i] <= ERASED_BYTE;
          end
        end
        OP_LOCK:  lock_q <= 1'b1;
        default:  ;
      endcase
    end
  end

  assign rd_byte = mem[rd_addr];
  assign locked  = lock_q;
endmodule

// File: rtl/nvm_status.sv
module nvm_status
  import nvm_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       busy,
  input  logic       start,
  input  logic [7:0] ld_byte,
  input  logic [7:0] arr_byte,
  output logic [7:0] rd_data,
  output logic       rd_oe
);
  logic       tog_q;
  logic [7:0] data_q;
  logic       oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog_q  <= 1'b0;
      data_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= rd_en;
      if (start)              tog_q <= 1'b0;
      else if (rd_en && busy) tog_q <= ~tog_q;
      if (rd_en) data_q <= busy ? poll_word(ld_byte, tog_q) : arr_byte;
    end
  end

  assign rd_data = data_q;
  assign rd_oe   = oe_q;
endmodule

// File: rtl/nvm_write_engine.sv
module nvm_write_engine
  import nvm_eng_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int BOOT_BYTES   = 16,
  parameter int PROG_CYCLES  = 8,
  parameter int ERASE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              hv_override,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              rd_oe,
  output logic              ready_line,
  output logic              boot_locked
);
  // Named internal events used by the checker.
  logic              busy;
  logic              done_evt;
  logic              cand_evt;
  logic              blocked_evt;
  logic              accept_evt;
  logic              in_boot;
  logic [7:0]        arr_byte;

  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        ld_byte;
  logic              keep_q;

  assign in_boot     = int'(req_addr) < BOOT_BYTES;
  assign cand_evt    = rst_n && req_valid && !busy;
  assign blocked_evt = cand_evt && (op_e'(req_op) == OP_PROG) && in_boot
                       && boot_locked && !hv_override;
  assign accept_evt  = cand_evt && (op_e'(req_op) != OP_NONE) && !blocked_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q    <= OP_NONE;
      addr_q  <= '0;
      ld_byte <= ERASED_BYTE;
      keep_q  <= 1'b0;
    end else if (accept_evt) begin
      op_q    <= op_e'(req_op);
      addr_q  <= req_addr;
      ld_byte <= (op_e'(req_op) == OP_PROG) ? req_data : ERASED_BYTE;
      keep_q  <= boot_locked && !hv_override;
    end
  end

  nvm_op_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) i_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept_evt),
    .long_op(op_e'(req_op) == OP_ERASE),
    .busy   (busy),
    .done   (done_evt)
  );

  nvm_array #(
    .ADDR_W    (ADDR_W),
    .BOOT_BYTES(BOOT_BYTES)
  ) i_array (
    .clk      (clk),
    .commit   (done_evt),
    .op       (op_q),
    .wr_addr  (addr_q),
    .wr_data  (ld_byte),
    .keep_boot(keep_q),
    .rd_addr  (rd_addr),
    .rd_byte  (arr_byte),
    .locked   (boot_locked)
  );

  nvm_status i_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .busy    (busy),
    .start   (accept_evt),
    .ld_byte (ld_byte),
    .arr_byte(arr_byte),
    .rd_data (rd_data),
    .rd_oe   (rd_oe)
  );

  assign ready_line = !busy;
endmodule

// File: rtl/nvm_write_engine_chk.sv
module nvm_write_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic       rd_oe,
  input logic       ready_line,
  input logic       boot_locked,
  input logic       busy,
  input logic       accept_evt,
  input logic       done_evt,
  input logic       blocked_evt,
  input logic [7:0] ld_byte
);
  assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !ready_line);

  assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> ready_line);

  assert_blocked_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_evt |=> ready_line);

  assert_poll_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (rd_data[7] == ~$past(ld_byte[7])));

  assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy && $past(rd_en && busy)) |=> (rd_data[6] != $past(rd_data[6])));

  assert_lock_sticky_R7: assert property (@(posedge clk)
    boot_locked |=> boot_locked);

  assert_reset_hiz_R10: assert property (@(posedge clk)
    !rst_n |=> !rd_oe);

  assert_oe_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_oe);
endmodule

bind nvm_write_engine nvm_write_engine_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .rd_oe      (rd_oe),
  .ready_line (ready_line),
  .boot_locked(boot_locked),
  .busy       (busy),
  .accept_evt (accept_evt),
  .done_evt   (done_evt),
  .blocked_evt(blocked_evt),
  .ld_byte    (ld_byte)
);

// File: tb/test_nvm_write_engine.sv
module test_nvm_write_engine;
  localparam int AW  = 6;
  localparam int PC  = 8;
  localparam int EC  = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'b00;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          hv_override = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          rd_oe;
  logic          ready_line;
  logic          boot_locked;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nvm_write_engine #(.ADDR_W(AW), .BOOT_BYTES(16), .PROG_CYCLES(PC), .ERASE_CYCLES(EC))
  i_nvm_write_engine (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Present one request for one cycle; returns at the negedge after the accepting edge.
  task automatic send(input logic [1:0] op, input int addr, input logic [7:0] data, input logic hv);
    req_valid = 1'b1; req_op = op; req_addr = AW'(addr); req_data = data; hv_override = hv;
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'b00; hv_override = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [7:0] val);
    rd_en = 1'b1; rd_addr = AW'(addr);
    @(negedge clk);
    rd_en = 1'b0;
    val = rd_data;
    chk("R11 oe", int'(rd_oe), 1);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!ready_line && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R10 oe in reset", int'(rd_oe), 0);
    rst_n = 1'b1; @(negedge clk);
    chk("R6 ready idle", int'(ready_line), 1);
    chk("R7 unlocked", int'(boot_locked), 0);
    rd(5, v); chk("R1 powerup FF", v, 8'hFF);
    @(negedge clk);
    chk("R11 oe off", int'(rd_oe), 0);
  endtask

  task automatic t_program;
    logic [7:0] v; int n;
    send(2'b01, 20, 8'hA5, 0); busy_len(n); chk("R6 prog len", n, PC);
    rd(20, v); chk("R1 prog", v, 8'hA5);
    send(2'b01, 20, 8'h3C, 0); busy_len(n);
    rd(20, v); chk("R1 and merge", v, 8'h24);
    send(2'b00, 20, 8'h00, 0);
    chk("R9 op none", int'(ready_line), 1);
  endtask

  task automatic t_polling;
    logic [7:0] v; int n;
    send(2'b01, 21, 8'h5A, 0);
    rd(50, v); chk("R4 poll first", v, 8'h80);
    rd(7, v);  chk("R5 toggle second", v, 8'hC0);
    rd(7, v);  chk("R5 toggle third", v, 8'h80);
    busy_len(n);
    rd(21, v); chk("R4 true data", v, 8'h5A);
  endtask

  task automatic t_ignore_busy;
    logic [7:0] v; int n;
    send(2'b01, 22, 8'h0F, 0);
    send(2'b01, 23, 8'h00, 0);
    busy_len(n); chk("R9 single op len", n, PC - 1);
    rd(23, v); chk("R9 ignored", v, 8'hFF);
    rd(22, v); chk("R1 first kept", v, 8'h0F);
  endtask

  task automatic t_erase;
    logic [7:0] v; int n;
    send(2'b01, 3, 8'h11, 0); busy_len(n);
    send(2'b10, 0, 8'h00, 0);
    rd(9, v); chk("R4 erase poll", v, 8'h00);
    busy_len(n); chk("R6 erase len", n, EC - 1);
    rd(20, v); chk("R2 erased main", v, 8'hFF);
    rd(3, v);  chk("R2 erased boot", v, 8'hFF);
  endtask

  task automatic t_lock;
    logic [7:0] v; int n;
    send(2'b11, 0, 8'h00, 0); busy_len(n); chk("R6 lock len", n, PC);
    chk("R7 locked", int'(boot_locked), 1);
    send(2'b01, 2, 8'h00, 0);
    chk("R8 refused", int'(ready_line), 1);
    rd(2, v); chk("R8 unchanged", v, 8'hFF);
    send(2'b01, 2, 8'h77, 1); chk("R8 override busy", int'(ready_line), 0);
    busy_len(n);
    rd(2, v); chk("R8 override prog", v, 8'h77);
    send(2'b01, 30, 8'h00, 0); busy_len(n);
    send(2'b10, 0, 8'h00, 0); busy_len(n);
    rd(2, v);  chk("R3 boot kept", v, 8'h77);
    rd(30, v); chk("R3 main erased", v, 8'hFF);
    send(2'b10, 0, 8'h00, 1); busy_len(n);
    rd(2, v);  chk("R3 override erase", v, 8'hFF);
  endtask

  task automatic t_abort;
    logic [7:0] v; int n;
    send(2'b01, 41, 8'h12, 0); busy_len(n);
    send(2'b01, 40, 8'h00, 0);
    @(negedge clk);
    rst_n = 1'b0; rd_en = 1'b1; rd_addr = AW'(41);
    @(negedge clk);
    chk("R10 hiz", int'(rd_oe), 0);
    rst_n = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    chk("R10 ready after", int'(ready_line), 1);
    chk("R7 lock survives", int'(boot_locked), 1);
    rd(41, v); chk("R10 neighbour kept", v, 8'h12);
    rd(40, v); chk("R10 target old or new", int'(v == 8'hFF || v == 8'h00), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_program;
    t_polling;
    t_ignore_busy;
    t_erase;
    t_lock;
    t_abort;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule